// File: doc/BRIEF.md
# Single-Cycle 8-Bit Load/Store Processor Core

This block is a small processor core. Its datapath is 8 bits wide and it runs a fixed set of sixteen operations encoded in 20-bit instruction words. Each instruction is fetched, decoded and executed in one rising clock edge, and the whole core runs from a single clock. The program counter is 8 bits. The instruction store, the data store and the register file are all held inside the block. A lookup of control words indexed by the opcode drives the datapath steering.

The enclosing system fills the instruction store through a write port. This is normally done while reset is held, and the core starts at address 0 when reset is released. Two peek ports read one register and one data-store byte combinationally. A test environment uses them to compare the architectural state against a model. The program counter is visible on its own output.

Register codes: 0 is the constant-zero register, 1 to 5 are the five temporaries, and 6 is the stack pointer. Codes 7 to 15 name no register.

Top module: `risc8_core`

## Requirements
- R1: While `rst_n` is low, the program counter is 0, every register reads 0 except the stack pointer (code 6), which reads 0xFF, and every data-store byte reads 0.
- R2: Word layout: the opcode is in bits [19:16]. Register-format words hold source A in [15:12], source B in [11:8], destination in [7:4] and shift amount in [3:0]. Opcodes 0 (add), 2 (sub), 4 (and), 6 (or) and 10 (nor) write the 8-bit result of A op B to the destination, wrapping modulo 256.
- R3: Immediate-format words hold source in [15:12], destination in [11:8] and an 8-bit immediate in [7:0]. Opcodes 1, 3, 5 and 7 write source plus, minus, AND and OR the zero-extended immediate to the destination.
- R4: Opcode 8 shifts source A left and opcode 9 shifts it right, by the unsigned 4-bit shift amount. Vacated bits fill with zero, so any amount of 8 or more yields 0.
- R5: Opcode 12 loads the byte at address (reg[[15:12]] + imm) mod 256 into register [11:8]. Opcode 11 stores register [11:8] at that address.
- R6: Opcode 13 branches when registers [15:12] and [11:8] are equal, and opcode 14 branches when they differ. A taken branch sets the PC to (PC + 1 + imm) mod 256, with the immediate acting as a signed offset. A branch that is not taken gives PC + 1.
- R7: Opcode 15 loads bits [15:8] into the PC. Bits [7:0] are zero in this format.
- R8: Register code 0 and codes 7 to 15 always read 0, and writes to them have no effect.
- R9: Every opcode from 0 to 12 advances the PC by exactly one per clock. Each clock retires one instruction.
- R10: The stack pointer (code 6) is an ordinary read/write register. It can be used as a base address and can be adjusted by immediate arithmetic.
- R11: The instruction store changes only on a clock edge where `prog_we` is high. The peek ports do not disturb execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Instruction-store write enable |
| prog_addr | input | 8 | Instruction-store write address |
| prog_word | input | 20 | Instruction word to write |
| peek_reg_sel | input | 4 | Register code to observe |
| peek_mem_addr | input | 8 | Data-store address to observe |
| pc_o | output | 8 | Current program counter |
| peek_reg_data | output | 8 | Value of the selected register |
| peek_mem_data | output | 8 | Byte at the observed data address |

## Verification
Every architectural state element reaches the ports within one clock after the instruction that changed it. The PC output shows a wrong control word or a wrong branch decision on the very next cycle. A wrong register or data-store value shows through the peek ports right after the write. If it is missed there, it shows later as a wrong branch path. The bench compares the PC every cycle against a model and reads back each written location in the cycle it was written, so a fault is seen at the first instruction it affects.

// File: rtl/risc8_pkg.sv
package risc8_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,  OP_ADDI = 4'd1,  OP_SUB  = 4'd2,  OP_SUBI = 4'd3,
      OP_AND  = 4'd4,  OP_ANDI = 4'd5,  OP_OR   = 4'd6,  OP_ORI  = 4'd7,
      OP_SLL  = 4'd8,  OP_SRL  = 4'd9,  OP_NOR  = 4'd10, OP_SW   = 4'd11,
      OP_LW   = 4'd12, OP_BEQ  = 4'd13, OP_BNE  = 4'd14, OP_JMP  = 4'd15
   } opcode_e;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLL, ALU_SRL, ALU_NOR
   } alu_fn_e;

   typedef enum logic [1:0] {
      NPC_SEQ, NPC_BEQ, NPC_BNE, NPC_JMP
   } npc_sel_e;

   typedef struct packed {
      logic     reg_we;
      logic     dst_is_rd;
      logic     use_imm;
      alu_fn_e  alu_fn;
      logic     mem_we;
      logic     load;
      npc_sel_e npc;
   } ctrl_word_t;

   function automatic ctrl_word_t ctrl_for(input logic [3:0] op);
      ctrl_word_t c;
      c.reg_we    = 1'b0;
      c.dst_is_rd = 1'b0;
      c.use_imm   = 1'b0;
      c.alu_fn    = ALU_ADD;
      c.mem_we    = 1'b0;
      c.load      = 1'b0;
      c.npc       = NPC_SEQ;
      case (op)
         OP_ADD:  begin c.reg_we = 1'b1; c.dst_is_rd = 1'b1; c.alu_fn = ALU_ADD; end
         OP_SUB:  begin c.reg_we = 1'b1; c.dst_is_rd = 1'b1; c.alu_fn = ALU_SUB; end
         OP_AND:  begin c.reg_we = 1'b1; c.dst_is_rd = 1'b1; c.alu_fn = ALU_AND; end
         OP_OR:   begin c.reg_we = 1'b1; c.dst_is_rd = 1'b1; c.alu_fn = ALU_OR;  end
         OP_NOR:  begin c.reg_we = 1'b1; c.dst_is_rd = 1'b1; c.alu_fn = ALU_NOR; end
         OP_SLL:  begin c.reg_we = 1'b1; c.dst_is_rd = 1'b1; c.alu_fn = ALU_SLL; end
         OP_SRL:  begin c.reg_we = 1'b1; c.dst_is_rd = 1'b1; c.alu_fn = ALU_SRL; end
         OP_ADDI: begin c.reg_we = 1'b1; c.use_imm = 1'b1; c.alu_fn = ALU_ADD; end
         OP_SUBI: begin c.reg_we = 1'b1; c.use_imm = 1'b1; c.alu_fn = ALU_SUB; end
         OP_ANDI: begin c.reg_we = 1'b1; c.use_imm = 1'b1; c.alu_fn = ALU_AND; end
         OP_ORI:  begin c.reg_we = 1'b1; c.use_imm = 1'b1; c.alu_fn = ALU_OR;  end
         OP_LW:   begin c.reg_we = 1'b1; c.use_imm = 1'b1; c.load = 1'b1; end
         OP_SW:   begin c.mem_we = 1'b1; c.use_imm = 1'b1; end
         OP_BEQ:  begin c.alu_fn = ALU_SUB; c.npc = NPC_BEQ; end
         OP_BNE:  begin c.alu_fn = ALU_SUB; c.npc = NPC_BNE; end
         OP_JMP:  begin c.npc = NPC_JMP; end
         default: ;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/risc8_regfile.sv
module risc8_regfile
   import risc8_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter int                SEL_W    = 4,
   parameter int                NUM_REGS = 7,
   parameter int                SP_IDX   = 6,
   parameter logic [DATA_W-1:0] SP_INIT  = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEL_W-1:0]  wsel,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SEL_W-1:0]  sel_a,
   input  logic [SEL_W-1:0]  sel_b,
   input  logic [SEL_W-1:0]  sel_p,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b,
   output logic [DATA_W-1:0] rd_p
);
   localparam int CODES = 1 << SEL_W;

   if (NUM_REGS < 2 || NUM_REGS > CODES) begin : g_bad_count
      $error("risc8_regfile: NUM_REGS must lie in 2..2**SEL_W");
   end
   if (SP_IDX < 1 || SP_IDX >= NUM_REGS) begin : g_bad_sp
      $error("risc8_regfile: SP_IDX must name a writable register");
   end

   logic [DATA_W-1:0] q [CODES];

   for (genvar g = 0; g < CODES; g++) begin : g_reg
      if (g == 0 || g >= NUM_REGS) begin : g_const
         assign q[g] = '0;
      end else begin : g_store
         localparam logic [DATA_W-1:0] INIT = (g == SP_IDX) ? SP_INIT : '0;
         logic [DATA_W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               r <= INIT;
            else if (we && wsel == SEL_W'(g))
               r <= wdata;
         end
         assign q[g] = r;
      end
   end

   assign rd_a = q[sel_a];
   assign rd_b = q[sel_b];
   assign rd_p = q[sel_p];

endmodule

// File: rtl/risc8_alu.sv
module risc8_alu
   import risc8_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int SH_W         = 4,
   parameter bit BARREL_SHIFT = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [SH_W-1:0]   sh,
   input  alu_fn_e           fn,
   output logic [DATA_W-1:0] y,
   output logic              zero
);
   logic [DATA_W-1:0] shl, shr;

   if (BARREL_SHIFT) begin : g_barrel
      always_comb begin
         shl = a;
         shr = a;
         for (int k = 0; k < SH_W; k++) begin
            if (sh[k]) begin
               if ((1 << k) >= DATA_W) begin
                  shl = '0;
                  shr = '0;
               end else begin
                  shl = shl << (1 << k);
                  shr = shr >> (1 << k);
               end
            end
         end
      end
   end else begin : g_operator
      assign shl = a << sh;
      assign shr = a >> sh;
   end

   always_comb begin
      unique case (fn)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_NOR: y = ~(a | b);
         ALU_SLL: y = shl;
         ALU_SRL: y = shr;
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/risc8_ctrl.sv
module risc8_ctrl
   import risc8_pkg::*;
#(
   parameter int OPC_W      = 4,
   parameter bit CTRL_TABLE = 1'b1
) (
   input  logic [OPC_W-1:0] opcode,
   output ctrl_word_t       cw
);
   localparam int ENTRIES = 1 << OPC_W;

   if (OPC_W != 4) begin : g_bad_opc
      $error("risc8_ctrl: opcode field must be 4 bits");
   end

   if (CTRL_TABLE) begin : g_table
      ctrl_word_t rom [ENTRIES];
      for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
         assign rom[g] = ctrl_for(4'(g));
      end
      assign cw = rom[opcode];
   end else begin : g_decode
      assign cw = ctrl_for(4'(opcode));
   end

endmodule

// File: rtl/risc8_dmem.sv
module risc8_dmem #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [ADDR_W-1:0] peek_addr,
   output logic [DATA_W-1:0] peek_data
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_depth
      $error("risc8_dmem: ADDR_W out of range");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata     = mem[addr];
   assign peek_data = mem[peek_addr];

endmodule

// File: rtl/risc8_core.sv
module risc8_core
   import risc8_pkg::*;
#(
   parameter int                DATA_W       = 8,
   parameter int                PC_W         = 8,
   parameter int                OPC_W        = 4,
   parameter int                FIELD_W      = 4,
   parameter int                INSTR_W      = 20,
   parameter int                NUM_REGS     = 7,
   parameter int                SP_IDX       = 6,
   parameter logic [DATA_W-1:0] SP_INIT      = 8'hFF,
   parameter bit                BARREL_SHIFT = 1'b1,
   parameter bit                CTRL_TABLE   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               prog_we,
   input  logic [PC_W-1:0]    prog_addr,
   input  logic [INSTR_W-1:0] prog_word,
   input  logic [FIELD_W-1:0] peek_reg_sel,
   input  logic [DATA_W-1:0]  peek_mem_addr,
   output logic [PC_W-1:0]    pc_o,
   output logic [DATA_W-1:0]  peek_reg_data,
   output logic [DATA_W-1:0]  peek_mem_data
);
   localparam int SEL_W    = FIELD_W;
   localparam int IMM_W    = INSTR_W - OPC_W - 2 * FIELD_W;
   localparam int OPC_LSB  = INSTR_W - OPC_W;
   localparam int RS_LSB   = OPC_LSB - FIELD_W;
   localparam int RT_LSB   = RS_LSB - FIELD_W;
   localparam int RD_LSB   = RT_LSB - FIELD_W;
   localparam int TGT_LSB  = OPC_LSB - PC_W;
   localparam int PC_DEPTH = 1 << PC_W;

   if (INSTR_W != OPC_W + 4 * FIELD_W) begin : g_bad_word
      $error("risc8_core: word must hold opcode plus four fields");
   end
   if (IMM_W != DATA_W || PC_W != DATA_W) begin : g_bad_imm
      $error("risc8_core: immediate, PC and data widths must agree");
   end
   if (TGT_LSB < 0 || RD_LSB != FIELD_W) begin : g_bad_layout
      $error("risc8_core: field layout does not fit the word");
   end

   logic [INSTR_W-1:0] imem [PC_DEPTH];
   logic [PC_W-1:0]    pc_q, pc_next, pc_inc, pc_br;
   logic [INSTR_W-1:0] instr;
   logic [OPC_W-1:0]   op;
   logic [SEL_W-1:0]   f_rs, f_rt, f_rd, f_sh, wsel;
   logic [IMM_W-1:0]   imm;
   logic [PC_W-1:0]    tgt;
   ctrl_word_t         cw;
   logic [DATA_W-1:0]  rd_a, rd_b, alu_b, alu_y, mem_rd, wb_data;
   logic               alu_zero;

   always_ff @(posedge clk) begin
      if (prog_we) imem[prog_addr] <= prog_word;
   end

   assign instr = imem[pc_q];
   assign op    = instr[OPC_LSB +: OPC_W];
   assign f_rs  = instr[RS_LSB  +: FIELD_W];
   assign f_rt  = instr[RT_LSB  +: FIELD_W];
   assign f_rd  = instr[RD_LSB  +: FIELD_W];
   assign f_sh  = instr[0       +: FIELD_W];
   assign imm   = instr[0       +: IMM_W];
   assign tgt   = instr[TGT_LSB +: PC_W];

   risc8_ctrl #(
      .OPC_W      (OPC_W),
      .CTRL_TABLE (CTRL_TABLE)
   ) u_ctrl (
      .opcode (op),
      .cw     (cw)
   );

   assign wsel = cw.dst_is_rd ? f_rd : f_rt;

   risc8_regfile #(
      .DATA_W   (DATA_W),
      .SEL_W    (SEL_W),
      .NUM_REGS (NUM_REGS),
      .SP_IDX   (SP_IDX),
      .SP_INIT  (SP_INIT)
   ) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cw.reg_we),
      .wsel  (wsel),
      .wdata (wb_data),
      .sel_a (f_rs),
      .sel_b (f_rt),
      .sel_p (peek_reg_sel),
      .rd_a  (rd_a),
      .rd_b  (rd_b),
      .rd_p  (peek_reg_data)
   );

   assign alu_b = cw.use_imm ? imm : rd_b;

   risc8_alu #(
      .DATA_W       (DATA_W),
      .SH_W         (FIELD_W),
      .BARREL_SHIFT (BARREL_SHIFT)
   ) u_alu (
      .a    (rd_a),
      .b    (alu_b),
      .sh   (f_sh),
      .fn   (cw.alu_fn),
      .y    (alu_y),
      .zero (alu_zero)
   );

   risc8_dmem #(
      .DATA_W (DATA_W),
      .ADDR_W (DATA_W)
   ) u_dmem (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cw.mem_we),
      .addr      (alu_y),
      .wdata     (rd_b),
      .rdata     (mem_rd),
      .peek_addr (peek_mem_addr),
      .peek_data (peek_mem_data)
   );

   assign wb_data = cw.load ? mem_rd : alu_y;

   assign pc_inc = pc_q + PC_W'(1);
   assign pc_br  = pc_inc + imm;

   always_comb begin
      unique case (cw.npc)
         NPC_BEQ: pc_next = alu_zero  ? pc_br : pc_inc;
         NPC_BNE: pc_next = !alu_zero ? pc_br : pc_inc;
         NPC_JMP: pc_next = tgt;
         default: pc_next = pc_inc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_next;
   end

   assign pc_o = pc_q;

endmodule

// File: rtl/risc8_core_chk.sv
module risc8_core_chk
   import risc8_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int PC_W     = 8,
   parameter int OPC_W    = 4,
   parameter int SEL_W    = 4,
   parameter int INSTR_W  = 20,
   parameter int NUM_REGS = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic [PC_W-1:0]    pc_o,
   input logic [INSTR_W-1:0] instr,
   input logic [DATA_W-1:0]  rd_a,
   input logic [DATA_W-1:0]  rd_b,
   input logic [SEL_W-1:0]   peek_reg_sel,
   input logic [DATA_W-1:0]  peek_reg_data
);
   logic [OPC_W-1:0] c_op;
   logic [PC_W-1:0]  c_imm, c_tgt;
   assign c_op  = instr[INSTR_W-1 -: OPC_W];
   assign c_imm = instr[PC_W-1:0];
   assign c_tgt = instr[INSTR_W-OPC_W-1 -: PC_W];

   assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (c_op < OP_BEQ) |=> pc_o == $past(pc_o) + PC_W'(1));

   assert_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (c_op == OP_JMP) |=> pc_o == $past(c_tgt));

   assert_beq_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (c_op == OP_BEQ && rd_a == rd_b) |=> pc_o == $past(pc_o) + PC_W'(1) + $past(c_imm));

   assert_beq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (c_op == OP_BEQ && rd_a != rd_b) |=> pc_o == $past(pc_o) + PC_W'(1));

   assert_bne_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (c_op == OP_BNE && rd_a != rd_b) |=> pc_o == $past(pc_o) + PC_W'(1) + $past(c_imm));

   assert_bne_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (c_op == OP_BNE && rd_a == rd_b) |=> pc_o == $past(pc_o) + PC_W'(1));

   assert_null_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (peek_reg_sel == '0 || peek_reg_sel >= SEL_W'(NUM_REGS)) |-> peek_reg_data == '0);

endmodule

bind risc8_core risc8_core_chk #(
   .DATA_W   (DATA_W),
   .PC_W     (PC_W),
   .OPC_W    (OPC_W),
   .SEL_W    (FIELD_W),
   .INSTR_W  (INSTR_W),
   .NUM_REGS (NUM_REGS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pc_o          (pc_o),
   .instr         (instr),
   .rd_a          (rd_a),
   .rd_b          (rd_b),
   .peek_reg_sel  (peek_reg_sel),
   .peek_reg_data (peek_reg_data)
);

// File: tb/risc8_core_test.sv
`timescale 1ns/100ps
module risc8_core_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prog_we = 1'b0;
   logic [7:0]  prog_addr = '0;
   logic [19:0] prog_word = '0;
   logic [3:0]  peek_reg_sel = '0;
   logic [7:0]  peek_mem_addr = '0;
   logic [7:0]  pc_o, peek_reg_data, peek_mem_data;

   always #4 clk = ~clk;

   risc8_core uut (
      .clk (clk), .rst_n (rst_n), .prog_we (prog_we), .prog_addr (prog_addr),
      .prog_word (prog_word), .peek_reg_sel (peek_reg_sel),
      .peek_mem_addr (peek_mem_addr), .pc_o (pc_o),
      .peek_reg_data (peek_reg_data), .peek_mem_data (peek_mem_data)
   );

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   logic [19:0] m_imem [256];
   logic [7:0]  m_reg  [16];
   logic [7:0]  m_mem  [256];
   logic [7:0]  m_pc;
   int          w_reg, w_mem, last_op;

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] m_rd(input logic [3:0] c);
      return (c == 0 || c >= 7) ? 8'h00 : m_reg[c];
   endfunction

   function automatic string req_of(input int op, input int code);
      if (code == 0 || code >= 7) return "R8";
      if (code == 6) return "R10";
      case (op)
         0, 2, 4, 6, 10: return "R2";
         1, 3, 5, 7:     return "R3";
         8, 9:           return "R4";
         default:        return "R5";
      endcase
   endfunction

   task automatic m_wr(input logic [3:0] c, input logic [7:0] v);
      w_reg = c;
      if (c != 0 && c < 7) m_reg[c] = v;
   endtask

   // reference model of one instruction, from the requirements
   task automatic m_step();
      logic [19:0] w;
      logic [3:0]  op, rs, rt, rd, sh;
      logic [7:0]  a, b, imm, ea, nxt;
      w = m_imem[m_pc];
      op = w[19:16]; rs = w[15:12]; rt = w[11:8]; rd = w[7:4]; sh = w[3:0];
      imm = w[7:0];
      a = m_rd(rs); b = m_rd(rt);
      ea = a + imm;
      nxt = m_pc + 8'd1;
      w_reg = -1; w_mem = -1; last_op = op;
      case (op)
         4'd0:  m_wr(rd, a + b);
         4'd1:  m_wr(rt, a + imm);
         4'd2:  m_wr(rd, a - b);
         4'd3:  m_wr(rt, a - imm);
         4'd4:  m_wr(rd, a & b);
         4'd5:  m_wr(rt, a & imm);
         4'd6:  m_wr(rd, a | b);
         4'd7:  m_wr(rt, a | imm);
         4'd8:  m_wr(rd, (sh >= 8) ? 8'h00 : 8'(a << sh));
         4'd9:  m_wr(rd, (sh >= 8) ? 8'h00 : 8'(a >> sh));
         4'd10: m_wr(rd, ~(a | b));
         4'd11: begin m_mem[ea] = b; w_mem = ea; end
         4'd12: m_wr(rt, m_mem[ea]);
         4'd13: if (a == b) nxt = m_pc + 8'd1 + imm;
         4'd14: if (a != b) nxt = m_pc + 8'd1 + imm;
         default: nxt = w[15:8];
      endcase
      m_pc = nxt;
   endtask

   task automatic load_and_reset();
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
      m_reg[6] = 8'hFF;
      for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
      m_pc = 8'h00;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         prog_we = 1'b1; prog_addr = 8'(i); prog_word = m_imem[i];
      end
      @(negedge clk);
      prog_we = 1'b0; prog_addr = 8'h0F; prog_word = 20'hABCDE;
      chk("R1", "pc in reset", pc_o, 8'h00);
      for (int c = 0; c < 8; c++) begin
         peek_reg_sel = 4'(c); #0.2;
         chk("R1", $sformatf("reg %0d in reset", c), peek_reg_data, (c == 6) ? 8'hFF : 8'h00);
      end
      foreach (m_mem[i]) if (i == 0 || i == 2 || i == 128 || i == 255) begin
         peek_mem_addr = 8'(i); #0.2;
         chk("R1", $sformatf("mem %h in reset", i), peek_mem_data, 8'h00);
      end
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run(input int cycles);
      for (int n = 0; n < cycles; n++) begin
         @(posedge clk);
         m_step();
         @(negedge clk);
         chk((last_op == 15) ? "R7" : (last_op >= 13) ? "R6" : "R9", "pc", pc_o, m_pc);
         if (w_reg >= 0) begin
            peek_reg_sel = 4'(w_reg); #0.5;
            chk(req_of(last_op, w_reg), $sformatf("reg %0d", w_reg), peek_reg_data, m_rd(4'(w_reg)));
         end
         if (w_mem >= 0) begin
            peek_mem_addr = 8'(w_mem); #0.5;
            chk("R5", $sformatf("mem %h", w_mem), peek_mem_data, m_mem[w_mem]);
         end
      end
   endtask

   function automatic logic [19:0] rand_word();
      logic [3:0] op, f1, f2, f3, f4;
      op = 4'($urandom % 16);
      f1 = ($urandom % 10 < 8) ? 4'($urandom % 7) : 4'($urandom % 16);
      f2 = ($urandom % 10 < 8) ? 4'($urandom % 7) : 4'($urandom % 16);
      f3 = ($urandom % 10 < 8) ? 4'($urandom % 7) : 4'($urandom % 16);
      f4 = 4'($urandom % 16);
      if (op == 4'd15) return {op, 8'($urandom), 8'h00};
      return {op, f1, f2, f3, f4};
   endfunction

   initial begin
      void'($urandom(32'd5309));
      // directed program
      for (int i = 0; i < 256; i++) m_imem[i] = 20'h0;
      m_imem[0]  = 20'h10196; // t0 = 0x96
      m_imem[1]  = 20'h10555; // t4 = 0x55
      m_imem[2]  = 20'h81023; // t1 = t0 << 3
      m_imem[3]  = 20'h91034; // t2 = t0 >> 4
      m_imem[4]  = 20'h81059; // t4 = t0 << 9
      m_imem[5]  = 20'h11077; // write to $zero
      m_imem[6]  = 20'hB6100; // store t0 at 0(sp)
      m_imem[7]  = 20'hC6400; // t3 = load 0(sp)
      m_imem[8]  = 20'hB6203; // store t1 at 3(sp), wraps to 0x02
      m_imem[9]  = 20'h36601; // sp = sp - 1
      m_imem[10] = 20'hD4102; // beq t3,t0 taken
      m_imem[11] = 20'h103FF; // skipped
      m_imem[12] = 20'h103FF; // skipped
      m_imem[13] = 20'hE4105; // bneq not taken
      m_imem[14] = 20'hA2050; // t4 = nor(t1, zero)
      m_imem[15] = 20'hF0F00; // jump to self
      load_and_reset();
      run(24);
      // hand-computed end state; prog_we low with live address/data: R11
      chk("R7",  "halt pc", pc_o, 8'h0F);
      peek_reg_sel = 4'd1; #0.2; chk("R3",  "t0", peek_reg_data, 8'h96);
      peek_reg_sel = 4'd2; #0.2; chk("R4",  "t1 shl 3", peek_reg_data, 8'hB0);
      peek_reg_sel = 4'd3; #0.2; chk("R6",  "t2 not clobbered by skipped words", peek_reg_data, 8'h09);
      peek_reg_sel = 4'd4; #0.2; chk("R5",  "t3 loaded", peek_reg_data, 8'h96);
      peek_reg_sel = 4'd5; #0.2; chk("R2",  "t4 nor", peek_reg_data, 8'h4F);
      peek_reg_sel = 4'd6; #0.2; chk("R10", "sp decremented", peek_reg_data, 8'hFE);
      peek_reg_sel = 4'd0; #0.2; chk("R8",  "zero reg", peek_reg_data, 8'h00);
      peek_mem_addr = 8'hFF; #0.2; chk("R10", "stack slot", peek_mem_data, 8'h96);
      peek_mem_addr = 8'h02; #0.2; chk("R5",  "wrapped address", peek_mem_data, 8'hB0);
      chk("R11", "store untouched at halt", pc_o, 8'h0F);
      // random programs
      for (int r = 0; r < 24; r++) begin
         for (int i = 0; i < 256; i++) m_imem[i] = rand_word();
         load_and_reset();
         run(150);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R9 watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule